// File: doc/BRIEF.md
# Handshake-to-Serial Protocol Bridge

This block is the glue between two mismatched ways of moving a two-byte token. One clock drives both sides. The sending side announces its token with a level-held trigger. While the trigger is high it drives the first byte (field a). When the trigger falls it drives the second byte (field b), and each phase may last any number of cycles. The receiving side expects a start-pulse frame: one cycle with start high and field a on its bus, then the very next cycle with start low and field b on its bus.

The bridge keeps the whole token in a register of two byte-wide fields under a small control FSM. It is built for minimum latency. The start pulse leaves in the same cycle the trigger falls, so field a is forwarded while field b is being captured, and the output frame never waits for a complete token. A done pulse marks the field-b output cycle. The bridge then waits for the trigger to rise again. Only one token is in flight at a time.

Neither side has valid/ready. The sending side has no ready, so it can never be stalled, and the bridge samples it every cycle. The receiving side cannot apply back-pressure: once the start pulse is issued, the two frame cycles follow back to back and the receiver must take both.

Top module: `hs2ser_bridge`

## Requirements
- R1: A synchronous active-high reset returns the bridge to idle. In the cycles that follow, start, done and the output bus are all 0, and any partly captured token is discarded, so no start pulse follows a trigger fall that was not preceded by a trigger-high cycle after reset.
- R2: Whenever neither start nor done is asserted, the output bus is driven to all zeros.
- R3: In the first cycle with the trigger low after one or more trigger-high cycles, start is 1 in that same cycle. The output bus carries the input byte from the last trigger-high cycle.
- R4: In the cycle after a start pulse, start is 0, done is 1, and the output bus carries the input byte sampled in the start cycle (field b).
- R5: While the trigger stays high, field a is recaptured every cycle. Earlier high-cycle bytes never reach the output.
- R6: Trigger-low cycles after field b has been captured, and idle trigger-low cycles before a transfer, are ignored. They produce no start pulse and no done pulse, and the bus stays zero.
- R7: Start is never high in two consecutive cycles. Each start pulse is followed by exactly one done pulse, one cycle later.
- R8: A trigger that rises during the done cycle begins the next transfer. Done and the output of field b are still issued in that cycle, and the byte on the input in that cycle is taken as the new field a.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock for both sides |
| rst | input | 1 | Synchronous reset, active high |
| hs_trig_i | input | 1 | Sender's trigger level (high: field a, falling/low: field b) |
| hs_data_i | input | BYTE_W | Sender's byte bus |
| ser_start_o | output | 1 | One-cycle frame start toward the receiver |
| ser_data_o | output | BYTE_W | Receiver byte bus (a with start, b the cycle after, else 0) |
| xfer_done_o | output | 1 | One-cycle pulse with the field-b output cycle |

## Verification
Two functions can fall in the same cycle. One is the done pulse that emits field b of one token. The other is the capture of field a for the next token, which happens when the sender raises its trigger right after a single field-b cycle. The bench provokes this with directed back-to-back transfers that have one-cycle phases, and with random phase lengths that include zero idle cycles. In that cycle it checks that done and the old field b still appear. It then checks that the next start pulse carries the new field a, which it computes independently from the drive history.

// File: rtl/hs2ser_pkg.sv
package hs2ser_pkg;

  // Control FSM states of the bridge
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,  // nothing taken, nothing sent
    ST_GRAB_A = 2'd1,  // trigger high, field a being captured
    ST_EMIT_B = 2'd2   // field b on the output, transfer completes
  } bridge_state_e;

  // Token field indices
  localparam int FIELD_A    = 0;
  localparam int FIELD_B    = 1;
  localparam int NUM_FIELDS = 2;

endpackage

// File: rtl/hs2ser_token_store.sv
module hs2ser_token_store
  import hs2ser_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NUM_FIELDS-1:0] load_i,
  input  logic [BYTE_W-1:0]     data_i,
  output logic [BYTE_W-1:0]     field_a_o,
  output logic [BYTE_W-1:0]     field_b_o
);

  localparam int TOKEN_W = NUM_FIELDS * BYTE_W;

  logic [TOKEN_W-1:0] token_q;

  // One byte-wide slot per field, each with its own load strobe
  for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_field
    always_ff @(posedge clk) begin
      if (rst) begin
        token_q[f*BYTE_W +: BYTE_W] <= '0;
      end else if (load_i[f]) begin
        token_q[f*BYTE_W +: BYTE_W] <= data_i;
      end
    end
  end

  assign field_a_o = token_q[FIELD_A*BYTE_W +: BYTE_W];
  assign field_b_o = token_q[FIELD_B*BYTE_W +: BYTE_W];

endmodule

// File: rtl/hs2ser_ctrl.sv
module hs2ser_ctrl
  import hs2ser_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  trig_i,
  output logic [NUM_FIELDS-1:0] load_o,
  output logic                  start_o,
  output logic                  done_o
);

  bridge_state_e state_q, state_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  // Mealy outputs: the start pulse follows the trigger fall in the same cycle
  always_comb begin
    state_d = state_q;
    load_o  = '0;
    start_o = 1'b0;
    done_o  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (trig_i) begin
          load_o[FIELD_A] = 1'b1;
          state_d         = ST_GRAB_A;
        end
      end
      ST_GRAB_A: begin
        if (trig_i) begin
          load_o[FIELD_A] = 1'b1;
        end else begin
          load_o[FIELD_B] = 1'b1;
          start_o         = 1'b1;
          state_d         = ST_EMIT_B;
        end
      end
      ST_EMIT_B: begin
        done_o = 1'b1;
        if (trig_i) begin
          load_o[FIELD_A] = 1'b1;
          state_d         = ST_GRAB_A;
        end else begin
          state_d = ST_IDLE;
        end
      end
      default: begin
        state_d = ST_IDLE;
      end
    endcase
  end

endmodule

// File: rtl/hs2ser_out_sel.sv
module hs2ser_out_sel #(
  parameter int BYTE_W = 8
) (
  input  logic              start_i,
  input  logic              done_i,
  input  logic [BYTE_W-1:0] field_a_i,
  input  logic [BYTE_W-1:0] field_b_i,
  output logic [BYTE_W-1:0] data_o
);

  always_comb begin
    if (start_i) begin
      data_o = field_a_i;
    end else if (done_i) begin
      data_o = field_b_i;
    end else begin
      data_o = '0;
    end
  end

endmodule

// File: rtl/hs2ser_bridge.sv
module hs2ser_bridge
  import hs2ser_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hs_trig_i,
  input  logic [BYTE_W-1:0] hs_data_i,
  output logic              ser_start_o,
  output logic [BYTE_W-1:0] ser_data_o,
  output logic              xfer_done_o
);

  logic [NUM_FIELDS-1:0] load;
  logic [BYTE_W-1:0]     field_a;
  logic [BYTE_W-1:0]     field_b;
  logic                  start;
  logic                  done;

  hs2ser_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .trig_i  (hs_trig_i),
    .load_o  (load),
    .start_o (start),
    .done_o  (done)
  );

  hs2ser_token_store #(.BYTE_W(BYTE_W)) u_store (
    .clk       (clk),
    .rst       (rst),
    .load_i    (load),
    .data_i    (hs_data_i),
    .field_a_o (field_a),
    .field_b_o (field_b)
  );

  hs2ser_out_sel #(.BYTE_W(BYTE_W)) u_sel (
    .start_i   (start),
    .done_i    (done),
    .field_a_i (field_a),
    .field_b_i (field_b),
    .data_o    (ser_data_o)
  );

  assign ser_start_o = start;
  assign xfer_done_o = done;

endmodule

// File: rtl/hs2ser_bridge_chk.sv
module hs2ser_bridge_chk #(
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              hs_trig_i,
  input logic [BYTE_W-1:0] hs_data_i,
  input logic              ser_start_o,
  input logic [BYTE_W-1:0] ser_data_o,
  input logic              xfer_done_o
);

  // Bus is zero outside the two frame cycles
  assert_idle_bus_R2: assert property (@(posedge clk) disable iff (rst)
    (!ser_start_o && !xfer_done_o) |-> (ser_data_o == '0));

  // Start only on a trigger fall, with the last high-cycle byte
  assert_start_on_fall_R3: assert property (@(posedge clk) disable iff (rst)
    ser_start_o |-> (!hs_trig_i && $past(hs_trig_i)));

  assert_start_data_R5: assert property (@(posedge clk) disable iff (rst)
    ser_start_o |-> (ser_data_o == $past(hs_data_i)));

  // Field b follows with done, carrying the byte of the start cycle
  assert_done_data_R4: assert property (@(posedge clk) disable iff (rst)
    xfer_done_o |-> (ser_data_o == $past(hs_data_i) && !ser_start_o));

  assert_start_then_done_R7: assert property (@(posedge clk) disable iff (rst)
    ser_start_o |=> (xfer_done_o && !ser_start_o));

  assert_done_needs_start_R7: assert property (@(posedge clk) disable iff (rst)
    xfer_done_o |-> $past(ser_start_o));

  // Start and done are never both high in one cycle
  assert_frame_exclusive_R6: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ser_start_o, xfer_done_o}));

endmodule

bind hs2ser_bridge hs2ser_bridge_chk #(.BYTE_W(BYTE_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .hs_trig_i   (hs_trig_i),
  .hs_data_i   (hs_data_i),
  .ser_start_o (ser_start_o),
  .ser_data_o  (ser_data_o),
  .xfer_done_o (xfer_done_o)
);

// File: tb/hs2ser_bridge_tb_top.sv
module hs2ser_bridge_tb_top;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst;
  logic         trig;
  logic [W-1:0] din;
  logic         start;
  logic [W-1:0] dout;
  logic         done;

  int tests_run = 0;
  int tests_fail = 0;
  int cycles = 0;
  bit finished = 1'b0;

  // Reference history built from the requirements
  bit         prev_trig = 1'b0;
  bit [W-1:0] prev_din = '0;
  bit         pend_done = 1'b0;
  bit [W-1:0] pend_b = '0;

  always #2 clk = ~clk;  // 250 MHz

  hs2ser_bridge #(.BYTE_W(W)) dut_i (
    .clk         (clk),
    .rst         (rst),
    .hs_trig_i   (trig),
    .hs_data_i   (din),
    .ser_start_o (start),
    .ser_data_o  (dout),
    .xfer_done_o (done)
  );

  // Expected start: first low cycle after a high cycle (R3)
  function automatic bit exp_start_f(bit pt, bit t);
    return pt && !t;
  endfunction

  // Expected bus: a with start (R3/R5), b with done (R4), else zero (R2)
  function automatic bit [W-1:0] exp_bus_f(bit st, bit dn, bit [W-1:0] a, bit [W-1:0] b);
    if (st) return a;
    if (dn) return b;
    return '0;
  endfunction

  task automatic check(string req, int act, int exp, string what);
    tests_run++;
    if (act != exp) begin
      tests_fail++;
      $display("FAIL %s %s: actual %0h expected %0h at cycle %0d", req, what, act, exp, cycles);
    end
  endtask

  // Drive one cycle (inputs set after negedge), then check just before posedge
  task automatic step(bit t, bit [W-1:0] d);
    bit         es;
    bit         ed;
    bit [W-1:0] eb;
    string      tag;
    @(negedge clk);
    trig = t;
    din  = d;
    es = exp_start_f(prev_trig, t);
    ed = pend_done;
    eb = exp_bus_f(es, ed, prev_din, pend_b);
    #1;
    tag = es ? "R3" : (ed ? (t ? "R8" : "R4") : (t ? "R2" : "R6"));
    check(tag, start, es, "start");
    check(ed ? tag : "R7", done, ed, "done");
    check(es ? "R5" : tag, dout, eb, "bus");
    pend_done = es;
    pend_b    = d;
    prev_trig = t;
    prev_din  = d;
  endtask

  task automatic do_reset(int n);
    @(negedge clk);
    rst  = 1'b1;
    trig = 1'b0;
    for (int i = 0; i < n; i++) @(negedge clk);
    rst = 1'b0;
    prev_trig = 1'b0;
    pend_done = 1'b0;
    #1;
    check("R1", start, 0, "start after reset");
    check("R1", done, 0, "done after reset");
    check("R1", dout, 0, "bus after reset");
  endtask

  // A transfer: idle cycles, high phase with changing a, low phase holding b
  task automatic xfer(int idle, int hi, int lo, bit [W-1:0] b);
    for (int i = 0; i < idle; i++) step(1'b0, W'($urandom));
    for (int i = 0; i < hi; i++) step(1'b1, W'($urandom));
    step(1'b0, b);
    for (int i = 1; i < lo; i++) step(1'b0, ((i % 2) == 0) ? b : W'($urandom));
  endtask

  initial begin
    void'($urandom(32'd20241));
    rst  = 1'b1;
    trig = 1'b0;
    din  = '0;
    do_reset(3);

    // Directed: minimal phases, back to back (R8)
    xfer(0, 1, 1, 8'hB1);
    xfer(0, 1, 1, 8'hB2);
    xfer(0, 1, 1, 8'hB3);
    // Directed: long high phase, a recaptured (R5)
    step(1'b1, 8'h11); step(1'b1, 8'h22); step(1'b1, 8'h33);
    step(1'b0, 8'hCC);
    // Directed: extra low cycles ignored (R6)
    step(1'b0, 8'hDD); step(1'b0, 8'hEE); step(1'b0, 8'hFF);
    // Directed: reset in mid high phase drops the token (R1)
    step(1'b1, 8'h5A);
    do_reset(1);
    step(1'b0, 8'h77);
    step(1'b0, 8'h78);
    // Directed: all-ones and zero bytes
    xfer(2, 1, 2, 8'hFF);
    step(1'b1, 8'h00);
    step(1'b0, 8'hFF);
    step(1'b0, 8'h00);

    // Random transfers
    for (int k = 0; k < 400; k++) begin
      xfer(int'($urandom_range(0, 3)), int'($urandom_range(1, 4)),
           int'($urandom_range(1, 4)), W'($urandom));
    end
    step(1'b0, '0);
    step(1'b0, '0);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests_run, tests_fail);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !finished) begin
      tests_run++;
      tests_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("[TB] %0d tests run, %0d failed", tests_run, tests_fail);
      $finish;
    end
  end

endmodule